// File: doc/BRIEF.md
# Recent-Instruction Loop Buffer

A small, fully associative store that sits beside the fetch stage and keeps the instructions fetched most recently. Each one is tagged with its full program counter. When a taken branch redirects fetch, the fetch stage presents the target PC as a lookup. On the following cycle the buffer answers with a response. On a hit, the response carries the stored instruction and its compressed flag. On a miss, the fetch stage obtains the instruction from the lower fetch path and delivers it on the fill port. The buffer then installs it in the slot holding the oldest entry.

Replacement follows a wrap-around write pointer, so slots are reused in the order they were filled. A fill for a PC that is already held rewrites that entry in place and does not consume a new slot. A flush input drops every entry in one cycle, for example after the instruction cache has been invalidated.

Top module: `recent_insn_cache`

## Requirements
- R1: After reset no entry is valid and `rsp_valid_o` is 0, so the first lookup of any PC reports a miss.
- R2: Every cycle with `lk_valid_i` high yields exactly one response, with `rsp_valid_o` high in the next cycle only. Without a lookup, `rsp_valid_o` stays low.
- R3: A lookup whose PC equals the tag of a valid entry reports `rsp_hit_o`=1, together with that entry's instruction and compressed flag.
- R4: A lookup that matches no valid entry reports `rsp_hit_o`=0, `rsp_insn_o`=0 and `rsp_cmp_o`=0.
- R5: A fill whose PC is not held is written into the slot at the write pointer, which then advances by one and wraps after DEPTH slots. With DEPTH=64, the 65th distinct fill evicts the first one, and the 66th evicts the second.
- R6: A fill whose PC is already held overwrites that entry's instruction and flag in place and does not advance the write pointer.
- R7: A flush invalidates every entry. A lookup in the flush cycle reports a miss. A fill in the flush cycle is discarded.
- R8: When a fill and a lookup for the same PC happen in the same cycle, and that PC was not held before, the lookup reports a miss. A lookup in the next cycle hits.
- R9: For a fill with `fill_cmp_i`=1, only bits 15:0 of `fill_insn_i` are kept. A hit on that entry returns bits 31:16 as zero and `rsp_cmp_o`=1.
- R10: Tags are compared over all PC_W bits. PCs that differ only in bit 39 are separate entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_pc_i | input | PC_W | Lookup PC |
| rsp_valid_o | output | 1 | Response valid, one cycle after the lookup |
| rsp_hit_o | output | 1 | Lookup PC found |
| rsp_insn_o | output | INSN_W | Instruction on hit, zero on miss |
| rsp_cmp_o | output | 1 | Compressed flag on hit |
| fill_valid_i | input | 1 | Fill valid |
| fill_pc_i | input | PC_W | Fill PC |
| fill_insn_i | input | INSN_W | Fill instruction |
| fill_cmp_i | input | 1 | Fill is a 16-bit compressed instruction |

## Verification
The bench fills a complete generation of 64 sequential PCs and rewrites one of them in place. It then adds new PCs one at a time. This separates true oldest-first replacement from a pointer that also advances on refills, because the two evict different slots. Lookups that coincide with a fill of the same PC, or with a flush, show whether stored state or incoming state is seen. Two PCs that differ only in the top bit expose any truncated tag compare. Compressed fills with garbage in the upper half check that only the low halfword is kept.

// File: rtl/recent_insn_cache.sv
module recent_insn_cache #(
  parameter int DEPTH  = 64,
  parameter int PC_W   = 40,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              lk_valid_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [INSN_W-1:0] rsp_insn_o,
  output logic              rsp_cmp_o,
  input  logic              fill_valid_i,
  input  logic [PC_W-1:0]   fill_pc_i,
  input  logic [INSN_W-1:0] fill_insn_i,
  input  logic              fill_cmp_i
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  cmp_q;
  logic [PC_W-1:0]   tag_q  [DEPTH];
  logic [INSN_W-1:0] insn_q [DEPTH];
  logic [IDX_W-1:0]  wptr_q;

  logic [DEPTH-1:0]  lk_match, fill_match;
  logic [IDX_W-1:0]  lk_idx, fill_idx, wr_idx;
  logic              lk_any, fill_any, wr_en;
  logic [INSN_W-1:0] fill_data;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lk_match[g]   = vld_q[g] && (tag_q[g] == lk_pc_i);
    assign fill_match[g] = vld_q[g] && (tag_q[g] == fill_pc_i);
  end

  always_comb begin
    lk_idx   = '0;
    fill_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_match[i])   lk_idx   = IDX_W'(i);
      if (fill_match[i]) fill_idx = IDX_W'(i);
    end
  end

  assign lk_any    = |lk_match;
  assign fill_any  = |fill_match;
  assign wr_en     = fill_valid_i && !flush_i;
  assign wr_idx    = fill_any ? fill_idx : wptr_q;
  assign fill_data = fill_cmp_i ? {{(INSN_W-16){1'b0}}, fill_insn_i[15:0]} : fill_insn_i;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= fill_pc_i;
      insn_q[wr_idx] <= fill_data;
      cmp_q[wr_idx]  <= fill_cmp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= '0;
      wptr_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_insn_o  <= '0;
      rsp_cmp_o   <= 1'b0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_valid_i && lk_any && !flush_i;
      rsp_insn_o  <= (lk_valid_i && lk_any && !flush_i) ? insn_q[lk_idx] : '0;
      rsp_cmp_o   <= (lk_valid_i && lk_any && !flush_i) ? cmp_q[lk_idx] : 1'b0;
      if (flush_i) begin
        vld_q  <= '0;
        wptr_q <= '0;
      end else if (fill_valid_i && !fill_any) begin
        vld_q[wptr_q] <= 1'b1;
        wptr_q <= (wptr_q == IDX_W'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |=> rsp_valid_o); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |=> !rsp_valid_o); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit_o |-> rsp_valid_o); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_insn_o == '0 && !rsp_cmp_o)); // R4
  AST_NEW_SLOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && !flush_i && !fill_any) |=> vld_q[$past(wptr_q)]); // R5
  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_match)); // R6
  AST_REFILL_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && !flush_i && fill_any) |=> $stable(wptr_q)); // R6
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && lk_valid_i) |=> !rsp_hit_o); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0)); // R7
  AST_SAME_CYCLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && fill_valid_i && lk_pc_i == fill_pc_i && !lk_any) |=> !rsp_hit_o); // R8
  AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit_o && rsp_cmp_o) |-> (rsp_insn_o[INSN_W-1:16] == '0)); // R9
endmodule

// File: tb/recent_insn_cache_tb_top.sv
module recent_insn_cache_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush_i = 0, lk_valid_i = 0, fill_valid_i = 0, fill_cmp_i = 0;
  logic [39:0] lk_pc_i = '0, fill_pc_i = '0;
  logic [31:0] fill_insn_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_cmp_o;
  logic [31:0] rsp_insn_o;

  int checks = 0, errors = 0;

  typedef struct { logic hit; logic [31:0] insn; logic cmp; string req; } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  recent_insn_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
    .rsp_insn_o(rsp_insn_o), .rsp_cmp_o(rsp_cmp_o),
    .fill_valid_i(fill_valid_i), .fill_pc_i(fill_pc_i),
    .fill_insn_i(fill_insn_i), .fill_cmp_i(fill_cmp_i));

  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2: response without lookup act=1 exp=0");
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (rsp_hit_o !== e.hit || rsp_insn_o !== e.insn || rsp_cmp_o !== e.cmp) begin
          errors++;
          $display("FAIL %s: act hit=%0b insn=%h cmp=%0b exp hit=%0b insn=%h cmp=%0b",
                   e.req, rsp_hit_o, rsp_insn_o, rsp_cmp_o, e.hit, e.insn, e.cmp);
        end
      end
    end
  end

  task automatic cyc(input logic lk, input logic [39:0] lpc,
                     input logic fv, input logic [39:0] fpc, input logic [31:0] fi,
                     input logic fc, input logic fl);
    lk_valid_i = lk; lk_pc_i = lpc;
    fill_valid_i = fv; fill_pc_i = fpc; fill_insn_i = fi; fill_cmp_i = fc;
    flush_i = fl;
    @(negedge clk);
    lk_valid_i = 0; fill_valid_i = 0; flush_i = 0;
  endtask

  task automatic look(input logic [39:0] pc, input logic h, input logic [31:0] ins,
                      input logic c, input string req);
    expq.push_back('{h, ins, c, req});
    cyc(1, pc, 0, '0, '0, 0, 0);
  endtask

  task automatic fill(input logic [39:0] pc, input logic [31:0] ins, input logic c);
    cyc(0, '0, 1, pc, ins, c, 0);
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    checks++;
    if (rsp_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL %s: rsp_valid act=%0b exp=0", req, rsp_valid_o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid_o !== 1'b0 || rsp_hit_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs act=%0b%0b exp=00", rsp_valid_o, rsp_hit_o);
    end
    rst_n = 1;
    @(negedge clk);
    look(40'h100, 0, 0, 0, "R1");
    idle_check("R2");
    // R3: plain hit
    fill(40'h1000, 32'h00A00093, 0);
    look(40'h1000, 1, 32'h00A00093, 0, "R3");
    // R9: compressed keeps low half only
    fill(40'h1004, 32'hDEAD4501, 1);
    look(40'h1004, 1, 32'h00004501, 1, "R9");
    // R4: unknown PC misses
    look(40'h5554, 0, 0, 0, "R4");
    // R8: fill and lookup same PC same cycle
    expq.push_back('{1'b0, 32'h0, 1'b0, "R8"});
    cyc(1, 40'h1008, 1, 40'h1008, 32'h11223344, 0, 0);
    look(40'h1008, 1, 32'h11223344, 0, "R8");
    // R10: top bit differs
    look(40'h80_0000_1000, 0, 0, 0, "R10");
    fill(40'h80_0000_1000, 32'hCAFEF00D, 0);
    look(40'h80_0000_1000, 1, 32'hCAFEF00D, 0, "R10");
    look(40'h1000, 1, 32'h00A00093, 0, "R10");
    // R7: flush with lookup and fill in the same cycle
    expq.push_back('{1'b0, 32'h0, 1'b0, "R7"});
    cyc(1, 40'h1000, 1, 40'h3000, 32'h77777777, 0, 1);
    look(40'h1000, 0, 0, 0, "R7");
    look(40'h3000, 0, 0, 0, "R7");
    look(40'h1004, 0, 0, 0, "R7");
    // R5 / R6: full generation, in-place refill, then eviction order
    for (int i = 0; i < 64; i++) fill(40'h2000 + 40'(4*i), 32'h1000 + 32'(i), 0);
    look(40'h2000, 1, 32'h1000, 0, "R5");
    look(40'h20FC, 1, 32'h103F, 0, "R5");
    fill(40'h2014, 32'h0000BEEF, 0);
    fill(40'h9000, 32'h00009000, 0);
    look(40'h2000, 0, 0, 0, "R5");
    look(40'h2004, 1, 32'h1001, 0, "R6");
    look(40'h2014, 1, 32'h0000BEEF, 0, "R6");
    look(40'h9000, 1, 32'h00009000, 0, "R5");
    fill(40'h9004, 32'h00009004, 0);
    look(40'h2004, 0, 0, 0, "R5");
    look(40'h2008, 1, 32'h1002, 0, "R5");
    look(40'h9004, 1, 32'h00009004, 0, "R5");
    idle_check("R2");
    repeat (2) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2: missing responses act=%0d exp=0", expq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule